// File: doc/BRIEF.md
# Time-Slot Switch Processor Access Port

This block sits between a microprocessor bus and the storage of a time-slot interchange switch. It decodes a 6-bit address, keeps an 8-bit control register, and turns each bus cycle into a read or a write strobe on one of three arrays: the data memory, the low half of the connection memory, or the high half of the connection memory. It also hands the processor-enable flag from the control register to the switching core.

Memory is reached indirectly. The top address line selects between the control register and memory. The five low address lines give the channel. The stream comes from the control register, as do the array choice and the split-memory flag. The bus is synchronous. Chip select, read and write are sampled on the rising clock edge. Read data shows on the output in the following cycle. Each array is assumed to have its own processor-side port, which has a one-cycle synchronous read.

Top module: `tsi_cpu_access`

## Requirements
- R1: After reset the control register is zero, `proc_en` is low, `cpu_rdata` is zero and no memory strobe is active.
- R2: A write with `cpu_addr[5]`=0 loads the control register. Bits 5 and 2 always read back as zero. A read with `cpu_addr[5]`=0 returns the control register on `cpu_rdata` in the next cycle.
- R3: `proc_en` equals control bit 6 and changes in the cycle after the control register is written.
- R4: For a memory access (`cpu_addr[5]`=1), `mem_addr` is {control bits 1:0 (stream), `cpu_addr[4:0]` (channel)}.
- R5: A memory write with select bits 4:3 = 10 pulses `cml_we`, and one with 11 pulses `cmh_we`. In both cases `mem_wdata` equals `cpu_wdata` and the split flag (bit 7) plays no part.
- R6: A memory write with select 01 (data memory) or 00 (no target) drives no write strobe and leaves every array unchanged.
- R7: With bit 7 clear, a memory read uses the select bits. 01 reads the data memory, 10 the low connection half and 11 the high half, and the data appears on `cpu_rdata` one cycle later. Select 00 returns zero.
- R8: With bit 7 set, every memory read goes to the data memory, whatever the select bits hold.
- R9: With `cpu_cs` low nothing is strobed or written. When read and write are both asserted, the write is carried out and the read is dropped. In any cycle after a cycle with no accepted read, `cpu_rdata` is zero.
- R10: At most one read enable is active at a time, and only the enable of the array chosen by R7/R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | Chip select |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request (wins over read) |
| cpu_addr | input | 6 | Bit 5: memory/register; bits 4:0: channel |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after the read |
| proc_en | output | 1 | Processor-enable flag to switch core |
| mem_addr | output | 7 | {stream, channel} for the arrays |
| mem_wdata | output | 8 | Write data for the connection arrays |
| dm_re | output | 1 | Data memory read enable |
| cml_re | output | 1 | Connection-low read enable |
| cml_we | output | 1 | Connection-low write enable |
| cmh_re | output | 1 | Connection-high read enable |
| cmh_we | output | 1 | Connection-high write enable |
| dm_rdata | input | 8 | Data memory read data |
| cml_rdata | input | 8 | Connection-low read data |
| cmh_rdata | input | 8 | Connection-high read data |

## Verification
A corrupt control register shows up in the same cycle as the next memory access. Strobes go to the wrong array or address, and `proc_en` flips one cycle after the bad write. A wrong read-source latch puts the wrong array's byte, or a stale nonzero value, on `cpu_rdata` exactly one cycle after the read. The bench therefore compares every strobe, the address and the read data against its model on every clock. Dropped or misrouted writes are caught by reading the location back through the port.

// File: rtl/tsi_cpu_pkg.sv
package tsi_cpu_pkg;

    typedef enum logic [1:0] {
        MSEL_NONE = 2'b00,
        MSEL_DM   = 2'b01,
        MSEL_CML  = 2'b10,
        MSEL_CMH  = 2'b11
    } msel_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_CTRL = 3'd1,
        SRC_DM   = 3'd2,
        SRC_CML  = 3'd3,
        SRC_CMH  = 3'd4
    } rsrc_e;

    localparam int CTRL_SPLIT_BIT = 7;
    localparam int CTRL_PE_BIT    = 6;
    localparam int CTRL_MSEL_HI   = 4;
    localparam int CTRL_MSEL_LO   = 3;
    localparam int CTRL_RSV_HI    = 5;
    localparam int CTRL_RSV_LO    = 2;

endpackage

// File: rtl/tsi_cpu_decode.sv
module tsi_cpu_decode
    import tsi_cpu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int ST_W   = 2,
    localparam int CH_W  = ADDR_W - 1,
    localparam int MA_W  = ST_W + CH_W
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              split,
    input  logic [1:0]        msel_bits,
    input  logic [ST_W-1:0]   stream,
    output logic              ctrl_we,
    output logic [MA_W-1:0]   mem_addr,
    output logic              dm_re,
    output logic              cml_re,
    output logic              cmh_re,
    output logic              cml_we,
    output logic              cmh_we,
    output rsrc_e             rsrc
);

    logic  wr_op;
    logic  rd_op;
    logic  to_mem;
    msel_e msel;

    always_comb begin
        wr_op    = cs & wr;
        rd_op    = cs & rd & ~wr;
        to_mem   = addr[ADDR_W-1];
        msel     = msel_e'(msel_bits);
        mem_addr = {stream, addr[CH_W-1:0]};

        ctrl_we  = wr_op & ~to_mem;
        cml_we   = wr_op & to_mem & (msel == MSEL_CML);
        cmh_we   = wr_op & to_mem & (msel == MSEL_CMH);

        rsrc = SRC_NONE;
        if (rd_op) begin
            if (!to_mem) begin
                rsrc = SRC_CTRL;
            end else if (split) begin
                rsrc = SRC_DM;
            end else begin
                case (msel)
                    MSEL_DM:  rsrc = SRC_DM;
                    MSEL_CML: rsrc = SRC_CML;
                    MSEL_CMH: rsrc = SRC_CMH;
                    default:  rsrc = SRC_NONE;
                endcase
            end
        end

        dm_re  = (rsrc == SRC_DM);
        cml_re = (rsrc == SRC_CML);
        cmh_re = (rsrc == SRC_CMH);
    end

    // Guards R10: read enables are mutually exclusive
    always_comb begin
        assert_read_onehot_R10: assert ($onehot0({dm_re, cml_re, cmh_re}))
            else $error("more than one read enable");
    end

endmodule

// File: rtl/tsi_cpu_ctrl_reg.sv
module tsi_cpu_ctrl_reg
    import tsi_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl
);

    localparam logic [DATA_W-1:0] KEEP_MASK =
        ~((DATA_W'(1) << CTRL_RSV_HI) | (DATA_W'(1) << CTRL_RSV_LO));

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.ctrl = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl = state_q.ctrl;

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CTRL_RSV_HI] == 1'b0) && (ctrl[CTRL_RSV_LO] == 1'b0))
        else $error("reserved control bit set");

endmodule

// File: rtl/tsi_cpu_rdmux.sv
module tsi_cpu_rdmux
    import tsi_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsrc_e             rsrc,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] dm_rdata,
    input  logic [DATA_W-1:0] cml_rdata,
    input  logic [DATA_W-1:0] cmh_rdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        rsrc_e sel;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.sel = rsrc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{sel: SRC_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (state_q.sel)
            SRC_CTRL: rdata = ctrl;
            SRC_DM:   rdata = dm_rdata;
            SRC_CML:  rdata = cml_rdata;
            SRC_CMH:  rdata = cmh_rdata;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tsi_cpu_access.sv
module tsi_cpu_access
    import tsi_cpu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int ST_W   = 2,
    localparam int MA_W  = ST_W + ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cs,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              proc_en,
    output logic [MA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dm_re,
    output logic              cml_re,
    output logic              cml_we,
    output logic              cmh_re,
    output logic              cmh_we,
    input  logic [DATA_W-1:0] dm_rdata,
    input  logic [DATA_W-1:0] cml_rdata,
    input  logic [DATA_W-1:0] cmh_rdata
);

    logic [DATA_W-1:0] ctrl_q;
    logic              ctrl_we;
    rsrc_e             rsrc;

    tsi_cpu_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (cpu_wdata),
        .ctrl  (ctrl_q)
    );

    tsi_cpu_decode #(.ADDR_W(ADDR_W), .ST_W(ST_W)) u_dec (
        .cs        (cpu_cs),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .addr      (cpu_addr),
        .split     (ctrl_q[CTRL_SPLIT_BIT]),
        .msel_bits (ctrl_q[CTRL_MSEL_HI:CTRL_MSEL_LO]),
        .stream    (ctrl_q[ST_W-1:0]),
        .ctrl_we   (ctrl_we),
        .mem_addr  (mem_addr),
        .dm_re     (dm_re),
        .cml_re    (cml_re),
        .cmh_re    (cmh_re),
        .cml_we    (cml_we),
        .cmh_we    (cmh_we),
        .rsrc      (rsrc)
    );

    tsi_cpu_rdmux #(.DATA_W(DATA_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsrc      (rsrc),
        .ctrl      (ctrl_q),
        .dm_rdata  (dm_rdata),
        .cml_rdata (cml_rdata),
        .cmh_rdata (cmh_rdata),
        .rdata     (cpu_rdata)
    );

    assign proc_en   = ctrl_q[CTRL_PE_BIT];
    assign mem_wdata = cpu_wdata;

    assert_proc_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && cpu_wr && !cpu_addr[ADDR_W-1]) |=> (proc_en == $past(cpu_wdata[CTRL_PE_BIT])))
        else $error("proc_en did not follow control write");

    assert_split_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && cpu_rd && !cpu_wr && cpu_addr[ADDR_W-1] && ctrl_q[CTRL_SPLIT_BIT])
        |-> (dm_re && !cml_re && !cmh_re))
        else $error("split-mode read not sent to data memory");

    assert_no_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_cs |-> !(dm_re || cml_re || cmh_re || cml_we || cmh_we))
        else $error("strobe without chip select");

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_cs && cpu_rd && !cpu_wr) |=> (cpu_rdata == '0))
        else $error("read data nonzero without a read");

    assert_dm_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_MSEL_HI:CTRL_MSEL_LO] == 2'b01 || ctrl_q[CTRL_MSEL_HI:CTRL_MSEL_LO] == 2'b00)
        |-> !(cml_we || cmh_we))
        else $error("write strobe while data memory or nothing selected");

endmodule

// File: tb/tsi_cpu_access_tb.sv
module tsi_cpu_access_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cs = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       proc_en;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       dm_re, cml_re, cml_we, cmh_re, cmh_we;
    logic [7:0] dm_rdata = '0, cml_rdata = '0, cmh_rdata = '0;

    always #10 clk = ~clk;

    tsi_cpu_access u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .proc_en(proc_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .dm_re(dm_re), .cml_re(cml_re), .cml_we(cml_we), .cmh_re(cmh_re), .cmh_we(cmh_we),
        .dm_rdata(dm_rdata), .cml_rdata(cml_rdata), .cmh_rdata(cmh_rdata)
    );

    // environment arrays with one-cycle synchronous read
    logic [7:0] dm_mem [128];
    logic [7:0] cml_mem[128];
    logic [7:0] cmh_mem[128];

    always @(posedge clk) begin
        if (dm_re)  dm_rdata  <= dm_mem[mem_addr];
        if (cml_re) cml_rdata <= cml_mem[mem_addr];
        if (cmh_re) cmh_rdata <= cmh_mem[mem_addr];
        if (cml_we) cml_mem[mem_addr] <= mem_wdata;
        if (cmh_we) cmh_mem[mem_addr] <= mem_wdata;
    end

    // reference model state
    int         checks = 0;
    int         errors = 0;
    logic [7:0] m_ctrl = '0;
    logic [7:0] exp_rdata = '0;
    string      pend_tag = "R1";
    int         dm_sh [128];
    int         cml_sh[128];
    int         cmh_sh[128];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic cs, input logic rd, input logic wr,
                       input logic [5:0] a, input logic [7:0] d, input string tag);
        logic wr_op, rd_op, mem, split;
        logic [1:0] msel;
        int idx;
        logic e_dmre, e_cmlre, e_cmhre, e_cmlwe, e_cmhwe;
        @(negedge clk);
        chk(pend_tag, "cpu_rdata", int'(cpu_rdata), int'(exp_rdata));
        chk("R3", "proc_en", int'(proc_en), int'(m_ctrl[6]));
        cpu_cs = cs; cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        #1;
        wr_op = cs && wr;
        rd_op = cs && rd && !wr;
        mem   = a[5];
        msel  = m_ctrl[4:3];
        split = m_ctrl[7];
        idx   = int'({m_ctrl[1:0], a[4:0]});
        e_cmlwe = wr_op && mem && msel == 2'b10;
        e_cmhwe = wr_op && mem && msel == 2'b11;
        e_dmre  = rd_op && mem && (split || msel == 2'b01);
        e_cmlre = rd_op && mem && !split && msel == 2'b10;
        e_cmhre = rd_op && mem && !split && msel == 2'b11;
        chk(tag, "dm_re",  int'(dm_re),  int'(e_dmre));
        chk(tag, "cml_re", int'(cml_re), int'(e_cmlre));
        chk(tag, "cmh_re", int'(cmh_re), int'(e_cmhre));
        chk(tag, "cml_we", int'(cml_we), int'(e_cmlwe));
        chk(tag, "cmh_we", int'(cmh_we), int'(e_cmhwe));
        if (e_dmre || e_cmlre || e_cmhre || e_cmlwe || e_cmhwe)
            chk("R4", "mem_addr", int'(mem_addr), idx);
        if (e_cmlwe || e_cmhwe)
            chk("R5", "mem_wdata", int'(mem_wdata), int'(d));
        if (rd_op && !mem)      exp_rdata = m_ctrl;
        else if (e_dmre)        exp_rdata = 8'(dm_sh[idx]);
        else if (e_cmlre)       exp_rdata = 8'(cml_sh[idx]);
        else if (e_cmhre)       exp_rdata = 8'(cmh_sh[idx]);
        else                    exp_rdata = 8'h00;
        pend_tag = tag;
        if (e_cmlwe) cml_sh[idx] = int'(d);
        if (e_cmhwe) cmh_sh[idx] = int'(d);
        if (wr_op && !mem) m_ctrl = d & 8'hDB;
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 1'b0, 1'b0, 6'h00, 8'h00, tag);
    endtask

    task automatic wctrl(input logic [7:0] v, input string tag);
        cyc(1'b1, 1'b0, 1'b1, 6'h00, v, tag);
    endtask

    task automatic wmem(input logic [4:0] ch, input logic [7:0] v, input string tag);
        cyc(1'b1, 1'b0, 1'b1, {1'b1, ch}, v, tag);
    endtask

    task automatic rmem(input logic [4:0] ch, input string tag);
        cyc(1'b1, 1'b1, 1'b0, {1'b1, ch}, 8'h00, tag);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            dm_mem[i]  = 8'((i * 5 + 3) & 255);
            dm_sh[i]   = (i * 5 + 3) & 255;
            cml_mem[i] = 8'h00; cml_sh[i] = 0;
            cmh_mem[i] = 8'h00; cmh_sh[i] = 0;
        end
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "cpu_rdata", int'(cpu_rdata), 0);
        chk("R1", "proc_en", int'(proc_en), 0);
        chk("R1", "strobes", int'({dm_re, cml_re, cml_we, cmh_re, cmh_we}), 0);
        rst_n = 1'b1;
        idle("R1");
        // R2 / R3: control register, reserved bits
        wctrl(8'hFF, "R2");
        cyc(1'b1, 1'b1, 1'b0, 6'h00, 8'h00, "R2");
        wctrl(8'h00, "R3");
        cyc(1'b1, 1'b1, 1'b0, 6'h1F, 8'h00, "R2");
        wctrl(8'h40, "R3");
        idle("R3");
        // R5 / R4: connection memory writes
        wctrl(8'h12, "R5");
        wmem(5'd5, 8'hA5, "R5");
        wmem(5'd31, 8'h3C, "R5");
        wctrl(8'h1A, "R5");
        wmem(5'd5, 8'h5A, "R5");
        wctrl(8'h18, "R4");
        wmem(5'd0, 8'h77, "R4");
        // R7: reads by select
        wctrl(8'h12, "R7");
        rmem(5'd5, "R7");
        rmem(5'd31, "R7");
        wctrl(8'h1A, "R7");
        rmem(5'd5, "R7");
        wctrl(8'h0A, "R7");
        rmem(5'd5, "R7");
        wctrl(8'h02, "R7");
        rmem(5'd5, "R7");
        // R6: writes with data memory or no target are dropped
        wctrl(8'h0A, "R6");
        wmem(5'd5, 8'hEE, "R6");
        rmem(5'd5, "R6");
        wctrl(8'h02, "R6");
        wmem(5'd5, 8'hEE, "R6");
        wctrl(8'h12, "R6");
        rmem(5'd5, "R6");
        wctrl(8'h1A, "R6");
        rmem(5'd5, "R6");
        // R8: split mode
        wctrl(8'h92, "R8");
        rmem(5'd5, "R8");
        wmem(5'd5, 8'h33, "R8");
        wctrl(8'h9A, "R8");
        rmem(5'd9, "R8");
        wmem(5'd9, 8'h44, "R8");
        wctrl(8'h12, "R8");
        rmem(5'd5, "R8");
        wctrl(8'h1A, "R8");
        rmem(5'd9, "R8");
        // R9: no chip select, and read+write together
        cyc(1'b0, 1'b1, 1'b1, 6'h00, 8'hFF, "R9");
        cyc(1'b0, 1'b1, 1'b1, 6'h25, 8'hFF, "R9");
        cyc(1'b1, 1'b1, 1'b0, 6'h00, 8'h00, "R9");
        cyc(1'b1, 1'b1, 1'b1, 6'h00, 8'h5B, "R9");
        cyc(1'b1, 1'b1, 1'b1, 6'h25, 8'h66, "R9");
        idle("R9");
        // R4 / R10: every stream, back-to-back reads
        for (int s = 0; s < 4; s++) begin
            wctrl(8'(8'h08 | s), "R4");
            rmem(5'(s * 7 + 1), "R4");
            rmem(5'(30 - s), "R10");
        end
        for (int s = 0; s < 4; s++) begin
            wctrl(8'(8'h10 | s), "R10");
            wmem(5'(s + 2), 8'(8'hC0 + s), "R10");
            rmem(5'(s + 2), "R10");
        end
        wctrl(8'h00, "R3");
        idle("R9");
        idle("R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule